// File: doc/BRIEF.md
# Search Request Command Decoder

This block sits at the command input of a search engine and turns each incoming request into a decoded operation. A request begins on the clock edge where the request strobe is sampled high. On that edge the decoder latches the instruction code, the lookup-type field, the mask-group select and the shared register-select field, which in this first cycle names the comparand register. On the next edge the same register-select field is read again, this time as the result register number.

After that second edge the decoder presents the decoded operation (lookup, learn, read, SRAM read, write, or no-op for reserved codes), the comparand and result register numbers, and the lookup type and mask group where the instruction uses them, with a one-cycle valid pulse. Fields that the instruction class does not use are forced to zero, so downstream logic always sees the same values for the same request. While the second cycle is in progress the block reports busy. A strobe in that cycle is not accepted and raises a one-cycle protocol-error pulse instead.

Top module: `search_cmd_decoder`

## Requirements
- R1: While reset is active and in the first cycle after it, busy, protoErr and outValid are 0 and outOp, outLType, outMask, outCmp and outRes are all zero.
- R2: A strobe sampled high while busy is 0 starts a request: busy is 1 for exactly the one cycle after that edge and 0 afterwards unless a new request starts.
- R3: outCmp equals the regSel value sampled on the edge that started the request.
- R4: outRes equals the regSel value sampled on the edge following the starting edge.
- R5: outValid is 1 for exactly one cycle, the cycle after the second edge of a request; the decoded outputs keep their values until the next outValid.
- R6: instrCode is decoded as 0 lookup, 1 learn, 2 read, 3 SRAM read, 4 write; outOp encodes 0 no-op, 1 lookup, 2 learn, 3 read, 4 SRAM read, 5 write.
- R7: outLType carries the sampled lookupType for lookup and learn and is 0 for every other operation.
- R8: outMask carries the sampled maskSel for lookup and write and is 0 for read, SRAM read, learn and no-op.
- R9: A strobe sampled high while busy is 1 is not accepted: no request starts, no extra outValid follows, and protoErr is 1 for the one cycle after that edge.
- R10: instrCode values 5, 6 and 7 are reserved and decode to outOp 0 with outLType, outMask, outCmp and outRes all 0.
- R11: A strobe sampled on the edge at which outValid becomes visible (the first cycle busy is 0 again) is accepted, so a new request may start every second cycle.
- R12: instrCode, lookupType and maskSel are sampled only on the starting edge; their values in the second cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStrobe | input | 1 | Request strobe, starts a request when sampled high while idle |
| instrCode | input | 3 | Instruction code |
| lookupType | input | LT_W | Lookup-type field |
| maskSel | input | MASK_W | Global-mask group select |
| regSel | input | REG_W | Shared register select: comparand, then result |
| busy | output | 1 | High during the second cycle of a request |
| protoErr | output | 1 | One-cycle pulse after a strobe that arrived while busy |
| outValid | output | 1 | One-cycle pulse marking a decoded request |
| outOp | output | 3 | Decoded operation code |
| outLType | output | LT_W | Lookup type, zero when unused |
| outMask | output | MASK_W | Mask group, zero when unused |
| outCmp | output | REG_W | Comparand register number |
| outRes | output | REG_W | Result register number |

## Verification
The assertions assume the strobe and the command fields are stable around the rising edge and that reset is held for at least one edge; the clocked properties compare outputs against input values two and one edges earlier. The stimulus drives every input on the falling edge, draws instruction codes across the full three-bit range including reserved codes, and in the second cycle of each request replaces the instruction, lookup-type and mask fields with fresh random values to show they are ignored. Strobes during busy and back-to-back starts are mixed in at random and also applied as directed cases.

// File: rtl/srcd_pkg.sv
package srcd_pkg;

  localparam int INSTR_W = 3;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_LOOKUP = 3'd1,
    OP_LEARN  = 3'd2,
    OP_READ   = 3'd3,
    OP_SRAMRD = 3'd4,
    OP_WRITE  = 3'd5
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capFirst;   // starting edge: latch command fields and comparand
    logic capSecond;  // second edge: latch result and publish
    logic drop;       // strobe refused while busy
  } ctl_s;

  function automatic op_e decodeOp(input logic [INSTR_W-1:0] code);
    case (code)
      3'd0:    return OP_LOOKUP;
      3'd1:    return OP_LEARN;
      3'd2:    return OP_READ;
      3'd3:    return OP_SRAMRD;
      3'd4:    return OP_WRITE;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic usesLType(input op_e op);
    return (op == OP_LOOKUP) || (op == OP_LEARN);
  endfunction

  function automatic logic usesMask(input op_e op);
    return (op == OP_LOOKUP) || (op == OP_WRITE);
  endfunction

endpackage

// File: rtl/srcd_ctrl.sv
module srcd_ctrl
  import srcd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqStrobe,
  output ctl_s ctl,
  output logic busy,
  output logic protoErr
);

  logic secondQ;

  always_comb begin
    ctl.capFirst  = reqStrobe & ~secondQ;
    ctl.capSecond = secondQ;
    ctl.drop      = reqStrobe & secondQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secondQ  <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      secondQ  <= ctl.capFirst;
      protoErr <= ctl.drop;
    end
  end

  assign busy = secondQ;

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && !busy) |=> busy);

  a_r2_busy_single: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  a_r9_err_on_hold: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && busy) |=> protoErr);

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(reqStrobe && busy));

endmodule

// File: rtl/srcd_datapath.sv
module srcd_datapath
  import srcd_pkg::*;
#(
  parameter int LT_W   = 2,
  parameter int MASK_W = 4,
  parameter int REG_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_s               ctl,
  input  logic [INSTR_W-1:0] instrCode,
  input  logic [LT_W-1:0]    lookupType,
  input  logic [MASK_W-1:0]  maskSel,
  input  logic [REG_W-1:0]   regSel,
  output logic               outValid,
  output op_e                outOp,
  output logic [LT_W-1:0]    outLType,
  output logic [MASK_W-1:0]  outMask,
  output logic [REG_W-1:0]   outCmp,
  output logic [REG_W-1:0]   outRes
);

  logic [INSTR_W-1:0] instrQ;
  logic [LT_W-1:0]    ltQ;
  logic [MASK_W-1:0]  maskQ;
  logic [REG_W-1:0]   cmpQ;
  op_e                opNext;

  assign opNext = decodeOp(instrQ);

  // First edge: hold the command fields and comparand number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrQ <= '0;
      ltQ    <= '0;
      maskQ  <= '0;
      cmpQ   <= '0;
    end else if (ctl.capFirst) begin
      instrQ <= instrCode;
      ltQ    <= lookupType;
      maskQ  <= maskSel;
      cmpQ   <= regSel;
    end
  end

  // Second edge: publish with unused fields forced to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outOp    <= OP_NOP;
      outLType <= '0;
      outMask  <= '0;
      outCmp   <= '0;
      outRes   <= '0;
    end else begin
      outValid <= ctl.capSecond;
      if (ctl.capSecond) begin
        outOp    <= opNext;
        outLType <= usesLType(opNext) ? ltQ : '0;
        outMask  <= usesMask(opNext) ? maskQ : '0;
        outCmp   <= (opNext == OP_NOP) ? '0 : cmpQ;
        outRes   <= (opNext == OP_NOP) ? '0 : regSel;
      end
    end
  end

  a_r3_cmp_from_first: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOp != OP_NOP) |-> outCmp == $past(regSel, 2));

  a_r4_res_from_second: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOp != OP_NOP) |-> outRes == $past(regSel));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outOp) && $stable(outCmp) && $stable(outRes)
                   && $stable(outLType) && $stable(outMask)));

  a_r8_mask_unused: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOp inside {OP_READ, OP_SRAMRD, OP_LEARN, OP_NOP})
      |-> outMask == '0);

  a_r10_nop_clear: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOp == OP_NOP)
      |-> (outLType == '0 && outMask == '0 && outCmp == '0 && outRes == '0));

endmodule

// File: rtl/search_cmd_decoder.sv
module search_cmd_decoder
  import srcd_pkg::*;
#(
  parameter int LT_W   = 2,
  parameter int MASK_W = 4,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStrobe,
  input  logic [2:0]        instrCode,
  input  logic [LT_W-1:0]   lookupType,
  input  logic [MASK_W-1:0] maskSel,
  input  logic [REG_W-1:0]  regSel,
  output logic              busy,
  output logic              protoErr,
  output logic              outValid,
  output logic [2:0]        outOp,
  output logic [LT_W-1:0]   outLType,
  output logic [MASK_W-1:0] outMask,
  output logic [REG_W-1:0]  outCmp,
  output logic [REG_W-1:0]  outRes
);

  ctl_s ctl;
  op_e  opQ;

  srcd_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqStrobe (reqStrobe),
    .ctl       (ctl),
    .busy      (busy),
    .protoErr  (protoErr)
  );

  srcd_datapath #(
    .LT_W   (LT_W),
    .MASK_W (MASK_W),
    .REG_W  (REG_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .instrCode  (instrCode),
    .lookupType (lookupType),
    .maskSel    (maskSel),
    .regSel     (regSel),
    .outValid   (outValid),
    .outOp      (opQ),
    .outLType   (outLType),
    .outMask    (outMask),
    .outCmp     (outCmp),
    .outRes     (outRes)
  );

  assign outOp = opQ;

endmodule

// File: tb/tb_search_cmd_decoder.sv
`timescale 1ns/1ps
module tb_search_cmd_decoder;

  localparam int LT_W   = 2;
  localparam int MASK_W = 4;
  localparam int REG_W  = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqStrobe = 1'b0;
  logic [2:0]        instrCode = '0;
  logic [LT_W-1:0]   lookupType = '0;
  logic [MASK_W-1:0] maskSel = '0;
  logic [REG_W-1:0]  regSel = '0;
  logic              busy, protoErr, outValid;
  logic [2:0]        outOp;
  logic [LT_W-1:0]   outLType;
  logic [MASK_W-1:0] outMask;
  logic [REG_W-1:0]  outCmp, outRes;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  search_cmd_decoder #(.LT_W(LT_W), .MASK_W(MASK_W), .REG_W(REG_W)) dut (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .instrCode(instrCode),
    .lookupType(lookupType), .maskSel(maskSel), .regSel(regSel),
    .busy(busy), .protoErr(protoErr), .outValid(outValid), .outOp(outOp),
    .outLType(outLType), .outMask(outMask), .outCmp(outCmp), .outRes(outRes)
  );

  // Expected values from the requirements (R6, R7, R8, R10)
  function automatic logic [2:0] expOp(input logic [2:0] code);
    return (code <= 3'd4) ? code + 3'd1 : 3'd0;
  endfunction

  function automatic logic [LT_W-1:0] expLt(input logic [2:0] code, input logic [LT_W-1:0] lt);
    return (code == 3'd0 || code == 3'd1) ? lt : '0;
  endfunction

  function automatic logic [MASK_W-1:0] expMask(input logic [2:0] code, input logic [MASK_W-1:0] m);
    return (code == 3'd0 || code == 3'd4) ? m : '0;
  endfunction

  function automatic logic [REG_W-1:0] expReg(input logic [2:0] code, input logic [REG_W-1:0] r);
    return (code <= 3'd4) ? r : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string tag, input logic [2:0] code, input logic [LT_W-1:0] lt,
                              input logic [MASK_W-1:0] m, input logic [REG_W-1:0] c,
                              input logic [REG_W-1:0] r);
    chk(outOp == expOp(code), {tag, " R6 op"}, outOp, expOp(code));
    chk(outLType == expLt(code, lt), {tag, " R7 ltype"}, outLType, expLt(code, lt));
    chk(outMask == expMask(code, m), {tag, " R8 mask"}, outMask, expMask(code, m));
    chk(outCmp == expReg(code, c), {tag, " R3 cmp"}, outCmp, expReg(code, c));
    chk(outRes == expReg(code, r), {tag, " R4 res"}, outRes, expReg(code, r));
  endtask

  // Called at a falling edge; leaves at a falling edge with strobe low.
  task automatic doRequest(input logic [2:0] code, input logic [LT_W-1:0] lt,
                           input logic [MASK_W-1:0] m, input logic [REG_W-1:0] c,
                           input logic [REG_W-1:0] r, input bit errStrobe, input bit gap);
    reqStrobe  = 1'b1;
    instrCode  = code;
    lookupType = lt;
    maskSel    = m;
    regSel     = c;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start (R11 when chained)", busy, 1);
    chk(outValid == 1'b0, "R5 no valid during busy", outValid, 0);
    // second cycle: other fields scrambled, they must be ignored (R12)
    reqStrobe  = errStrobe;
    regSel     = r;
    instrCode  = 3'($urandom);
    lookupType = LT_W'($urandom);
    maskSel    = MASK_W'($urandom);
    @(negedge clk);
    chk(outValid == 1'b1, "R5 valid pulse", outValid, 1);
    chk(protoErr == errStrobe, "R9 protoErr", protoErr, errStrobe);
    chk(busy == 1'b0, "R2 busy single cycle", busy, 0);
    checkOutputs("R12 decode", code, lt, m, c, r);
    reqStrobe = 1'b0;
    if (gap) begin
      @(negedge clk);
      chk(outValid == 1'b0, "R5 valid one cycle", outValid, 0);
      chk(busy == 1'b0, "R9 held-off strobe not accepted", busy, 0);
      chk(protoErr == 1'b0, "R9 err single cycle", protoErr, 0);
      checkOutputs("R5 hold", code, lt, m, c, r);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && protoErr == 0 && outValid == 0, "R1 flags in reset", {busy, protoErr, outValid}, 0);
    reqStrobe = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 strobe ignored in reset", busy, 0);
    reqStrobe = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(outOp == 0 && outLType == 0 && outMask == 0 && outCmp == 0 && outRes == 0,
        "R1 fields zero after reset", {outOp, outLType, outMask, outCmp, outRes}, 0);
    chk(busy == 0 && outValid == 0, "R1 idle after reset", {busy, outValid}, 0);

    // Directed: each instruction class (R6, R7, R8)
    doRequest(3'd0, 2'd3, 4'hA, 4'd5, 4'd9, 1'b0, 1'b1);
    doRequest(3'd1, 2'd2, 4'hF, 4'd1, 4'd2, 1'b0, 1'b1);
    doRequest(3'd2, 2'd3, 4'hF, 4'd7, 4'd8, 1'b0, 1'b1);
    doRequest(3'd3, 2'd1, 4'h3, 4'd15, 4'd0, 1'b0, 1'b1);
    doRequest(3'd4, 2'd3, 4'h6, 4'd12, 4'd14, 1'b0, 1'b1);
    // R10 reserved codes
    doRequest(3'd5, 2'd3, 4'hF, 4'd15, 4'd15, 1'b0, 1'b1);
    doRequest(3'd7, 2'd1, 4'h9, 4'd3, 4'd4, 1'b0, 1'b1);
    // R9 strobe during busy
    doRequest(3'd0, 2'd1, 4'h5, 4'd2, 4'd11, 1'b1, 1'b1);
    // R11 back-to-back
    doRequest(3'd4, 2'd0, 4'h1, 4'd6, 4'd7, 1'b0, 1'b0);
    doRequest(3'd1, 2'd3, 4'h2, 4'd8, 4'd9, 1'b0, 1'b0);
    doRequest(3'd0, 2'd2, 4'hC, 4'd10, 4'd13, 1'b1, 1'b1);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      doRequest(3'($urandom), LT_W'($urandom), MASK_W'($urandom),
                REG_W'($urandom), REG_W'($urandom),
                ($urandom % 8) == 0, ($urandom % 3) != 0);
    end
    @(negedge clk);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule